// File: doc/BRIEF.md
# Periodic Real-Time Tick Generator with Seconds Counter

This block produces a steady stream of interrupt requests at a programmable interval. Each request is one clock wide. Software or a neighbouring controller loads the interval as a 32-bit count of clock cycles. From then on the block fires at the end of every period and re-arms itself for the next one without further help.

Every request also advances a running tick count that belongs to this instance alone. Each group of 1024 requests makes one second, and at that point the block advances a seconds value that wraps from 59 back to 0. The tick that rolls the seconds over still raises its interrupt like any other tick.

The timing core is a two-state machine:
- `ST_IDLE`: after reset, and whenever an interval of 0 is loaded. No ticks are produced.
- `ST_RUN`: a down-counter runs and expires once per period.

It has four transitions:
- *start* takes `ST_IDLE` to `ST_RUN` when a nonzero interval is loaded.
- *stop* takes `ST_RUN` to `ST_IDLE` when an interval of 0 is loaded.
- *reload* keeps `ST_RUN` when a nonzero interval is loaded while running, and restarts the period.
- *expire* keeps `ST_RUN` when the counter reaches zero. It emits a tick and re-arms the counter.

Top module: `rtc_periodic_tick`

## Requirements
- R1: After reset `irq` is 0, `seconds` is 0 and `irq_count` is 0. No `irq` appears until a nonzero interval has been loaded.
- R2: An interval value is taken in a cycle with `load_valid` high. When N is loaded, the first `irq` is seen N+1 cycles after that cycle, and later ones every N cycles.
- R3: For N of 2 or more, `irq` is high for exactly one cycle per tick.
- R4: Loading a nonzero interval while running restarts the period from the load. If the load coincides with the cycle in which the period would have expired, that tick is suppressed and the next one follows the new interval.
- R5: Loading an interval of 0 stops all ticks. `irq_count` and `seconds` then hold their values.
- R6: Each tick raises `irq_count` by exactly one while it is below 1023. Without a tick, `irq_count` and `seconds` do not change.
- R7: On a tick that finds `irq_count` at 1023, `irq_count` returns to 0 and `seconds` advances by one. `irq` is still asserted on that tick.
- R8: `seconds` counts 0 to 59. A second boundary at 59 returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load strobe for a new interval |
| load_value | input | 32 | Interval in clock cycles; 0 stops the block |
| irq | output | 1 | One-cycle interrupt request per tick |
| seconds | output | 6 | Seconds value, 0 to 59 |
| irq_count | output | 10 | Ticks counted inside the current second |

## Verification
Two events can land in the same cycle: a new interval being loaded, and the running period expiring. The bench provokes this by waiting exactly N-1 cycles after a pulse of a 4-cycle period before it loads a 6-cycle interval, so the load arrives in the cycle of the expiry. The check is that no pulse comes from the old period and that the next pulse is seen seven cycles later. A second collision occurs when the 1024th tick of a second also rolls the seconds over. There the bench confirms that `irq` is high, `irq_count` is 0 and `seconds` has moved, all in the same sampled cycle.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tick_state_e;

endpackage

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer
    import rtc_tick_pkg::*;
#(
    parameter int INTERVAL_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_valid,
    input  logic [INTERVAL_W-1:0] load_value,
    output logic                  expire,
    output logic                  irq
);

    localparam logic [INTERVAL_W-1:0] ONE = INTERVAL_W'(1);

    tick_state_e           state_q, state_d;
    logic [INTERVAL_W-1:0] cnt_q;
    logic [INTERVAL_W-1:0] period_q;
    logic                  irq_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_valid && load_value != '0) state_d = ST_RUN;  // start
            ST_RUN:  if (load_valid && load_value == '0) state_d = ST_IDLE; // stop
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode: a load in the same cycle wins over expiry
    always_comb begin
        expire = (state_q == ST_RUN) && !load_valid && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            period_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= expire;
            if (load_valid) begin
                period_q <= load_value;
                cnt_q    <= load_value - ONE;
            end else if (expire) begin
                cnt_q <= period_q - ONE;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign irq = irq_q;

    // R3
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && period_q != ONE) |=> !irq_q);

    // R5
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_value == '0) |=> ##1 !irq_q);

endmodule

// File: rtl/rtc_second_accum.sv
module rtc_second_accum #(
    parameter int TICKS_PER_SEC = 1024,
    parameter int SEC_MOD       = 60,
    localparam int CW = $clog2(TICKS_PER_SEC),
    localparam int SW = $clog2(SEC_MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] irq_count,
    output logic [SW-1:0] seconds
);

    localparam logic [CW-1:0] CNT_LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_MOD - 1);

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sec_q <= '0;
        end else if (tick) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign irq_count = cnt_q;
    assign seconds   = sec_q;

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != CNT_LAST) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)) && $stable(sec_q));

    // R6
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_q) && $stable(sec_q)));

    // R7
    second_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == CNT_LAST) |=> (cnt_q == '0) && (sec_q != $past(sec_q)));

    // R8
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q <= SEC_LAST);

endmodule

// File: rtl/rtc_periodic_tick.sv
module rtc_periodic_tick #(
    parameter int INTERVAL_W    = 32,
    parameter int TICKS_PER_SEC = 1024,
    parameter int SEC_MOD       = 60,
    localparam int CW = $clog2(TICKS_PER_SEC),
    localparam int SW = $clog2(SEC_MOD)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_valid,
    input  logic [INTERVAL_W-1:0] load_value,
    output logic                  irq,
    output logic [SW-1:0]         seconds,
    output logic [CW-1:0]         irq_count
);

    logic expire;

    rtc_interval_timer #(
        .INTERVAL_W (INTERVAL_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_value (load_value),
        .expire     (expire),
        .irq        (irq)
    );

    rtc_second_accum #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SEC_MOD       (SEC_MOD)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (expire),
        .irq_count (irq_count),
        .seconds   (seconds)
    );

    // R7
    irq_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $changed(seconds)) |-> (irq_count == '0));

endmodule

// File: tb/rtc_periodic_tick_test.sv
module rtc_periodic_tick_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_value = '0;
    logic        irq;
    logic [5:0]  seconds;
    logic [9:0]  irq_count;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_periodic_tick uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_value (load_value),
        .irq        (irq),
        .seconds    (seconds),
        .irq_count  (irq_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic do_load(input int v);
        load_valid = 1'b1;
        load_value = 32'(v);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!irq && n < 5000);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        exp_cnt = 0;
    endtask

    task automatic t_reset_idle();
        int seen = 0;
        apply_reset();
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        check(seconds == 0, "R1 seconds", int'(seconds), 0);
        check(irq_count == 0, "R1 irq_count", int'(irq_count), 0);
        for (int i = 0; i < 20; i++) begin
            step();
            if (irq) seen++;
        end
        check(seen == 0, "R1 idle no irq", seen, 0);
    endtask

    task automatic t_period();
        int n;
        do_load(5);
        wait_irq(n);
        check(n == 6, "R2 first latency", n, 6);
        exp_cnt++;
        check(int'(irq_count) == exp_cnt, "R6 count step", int'(irq_count), exp_cnt);
        step();
        check(irq == 1'b0, "R3 pulse width", int'(irq), 0);
        wait_irq(n);
        check(n == 4, "R2 period remainder", n, 4);
        exp_cnt++;
        wait_irq(n);
        check(n == 5, "R2 period", n, 5);
        exp_cnt++;
        check(int'(irq_count) == exp_cnt, "R6 count step", int'(irq_count), exp_cnt);
    endtask

    task automatic t_reload();
        int n;
        step();
        step();
        do_load(7);
        wait_irq(n);
        check(n == 8, "R4 reload restart", n, 8);
        exp_cnt++;
        wait_irq(n);
        check(n == 7, "R4 new period", n, 7);
        exp_cnt++;
        check(int'(irq_count) == exp_cnt, "R6 count after reload", int'(irq_count), exp_cnt);
    endtask

    task automatic t_collision();
        int n;
        do_load(4);
        wait_irq(n);
        check(n == 5, "R2 latency N=4", n, 5);
        exp_cnt++;
        repeat (3) step();
        check(irq == 1'b0, "R3 low before expiry", int'(irq), 0);
        do_load(6);
        wait_irq(n);
        check(n == 7, "R4 load on expiry suppresses tick", n, 7);
        exp_cnt++;
        check(int'(irq_count) == exp_cnt, "R4 no extra count", int'(irq_count), exp_cnt);
    endtask

    task automatic t_stop();
        int seen = 0;
        int c0, s0;
        step();
        do_load(0);
        c0 = int'(irq_count);
        s0 = int'(seconds);
        for (int i = 0; i < 40; i++) begin
            step();
            if (irq) seen++;
        end
        check(seen == 0, "R5 stopped no irq", seen, 0);
        check(int'(irq_count) == c0, "R5 count held", int'(irq_count), c0);
        check(int'(seconds) == s0, "R5 seconds held", int'(seconds), s0);
    endtask

    task automatic t_seconds();
        int n;
        apply_reset();
        do_load(2);
        for (int i = 0; i < 1023; i++) wait_irq(n);
        check(irq_count == 10'd1023, "R6 count reaches 1023", int'(irq_count), 1023);
        check(seconds == 0, "R6 seconds before roll", int'(seconds), 0);
        wait_irq(n);
        check(irq == 1'b1, "R7 irq on roll tick", int'(irq), 1);
        check(irq_count == 0, "R7 count wraps", int'(irq_count), 0);
        check(seconds == 1, "R7 seconds advance", int'(seconds), 1);
        for (int i = 0; i < 58 * 1024; i++) wait_irq(n);
        check(seconds == 59, "R8 seconds at 59", int'(seconds), 59);
        for (int i = 0; i < 1024; i++) wait_irq(n);
        check(seconds == 0, "R8 seconds wrap", int'(seconds), 0);
        check(irq_count == 0, "R8 count at wrap", int'(irq_count), 0);
    endtask

    initial begin
        t_reset_idle();
        t_period();
        t_reload();
        t_collision();
        t_stop();
        t_seconds();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule